// File: doc/BRIEF.md
# SDI Channel Scrambler and NRZI Encoder

This block applies serial-digital-interface channel coding to a stream of parallel video words. Each word first passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. The scrambled bits then pass through an NRZI stage with generator x + 1. The word is 10 bits wide for standard definition or 20 bits wide for high definition, and a parameter chooses the width.

Inside a word, the bits form a serial stream whose first bit is the LSB. The scrambler history and the last NRZI output bit carry from one word to the next, so the coded stream is the same as a one-bit-at-a-time coder would make. A clock enable marks each input word. The coded word appears on the output one clock after the word is accepted. The output feeds a serializer, which is outside this block.

Top module: `sdi_chan_encoder`

## Requirements
- R1: After reset, `data_o`, the 9-bit scrambler history and the NRZI output bit are all zero. A reset applied in mid-stream returns the output to zero and restarts the coding from that zero state.
- R2: Bit 0 of a word is the earliest bit in the stream. The scrambled bit is s[n] = d[n] ^ s[n-4] ^ s[n-9], and the indices reach back into earlier words. From reset, the single word 10'h001 scrambles to 10'h311.
- R3: The output bit is y[n] = s[n] ^ y[n-1]. From reset, the 10-bit word 10'h001 encodes to 10'h10F.
- R4: The scrambler history and the NRZI bit carry across word boundaries. The output stream equals a continuous bit-serial coding of all accepted words, taken in order.
- R5: A cycle with `ce_i` low accepts no word. `data_o` holds its value, and the next accepted word is coded as if the idle cycle had not happened.
- R6: A word accepted at a rising edge with `ce_i` high is on `data_o` right after that edge.
- R7: `WIDTH` is 10 or 20. Any other value stops elaboration.
- R8: The output can be recovered by an NRZI decode, y[n] ^ y[n-1], followed by the descramble d[n] = s[n] ^ s[n-4] ^ s[n-9]. Starting from zero state, this recovers every accepted input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Accept `data_i` this cycle |
| data_i | input | WIDTH | Parallel word, LSB first in time |
| data_o | output | WIDTH | Coded word, registered |

## Verification
The hardest case to reach is a scrambler feedback tap that lands in an earlier word after idle cycles have passed. The tap at n-9 reaches back over a word boundary, and a skipped or misordered history bit only shows up several words later. The stimulus drives long random runs with `ce_i` low on about a quarter of the cycles. It checks each word against a bit-serial model and also runs a separate descrambler over the output. Directed impulse words, all-ones words and a mid-stream reset cover the cases where the feedback starts from a known state.

// File: rtl/sdi_coding_pkg.sv
package sdi_coding_pkg;
  localparam int unsigned SCR_LEN = 9;  // x^9 term
  localparam int unsigned SCR_TAP = 4;  // x^4 term
  localparam int unsigned WIDTH_SD = 10;
  localparam int unsigned WIDTH_HD = 20;
  typedef logic [SCR_LEN-1:0] scr_hist_t;
endpackage

// File: rtl/sdi_scrambler.sv
module sdi_scrambler
  import sdi_coding_pkg::*;
#(
  parameter int unsigned WIDTH = 20
) (
  input  logic [WIDTH-1:0] data_i,
  input  scr_hist_t        hist_i,  // [SCR_LEN-1] is most recent bit
  output logic [WIDTH-1:0] scr_o,
  output scr_hist_t        hist_o
);
  localparam int unsigned EXT_W = WIDTH + SCR_LEN;
  localparam int unsigned TAP_OFS = SCR_LEN - SCR_TAP;

  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = '0;
    ext[SCR_LEN-1:0] = hist_i;
    for (int i = 0; i < WIDTH; i++) begin
      ext[i+SCR_LEN] = data_i[i] ^ ext[i+TAP_OFS] ^ ext[i];
    end
  end

  assign scr_o  = ext[EXT_W-1:SCR_LEN];
  assign hist_o = ext[EXT_W-1:WIDTH];
endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi #(
  parameter int unsigned WIDTH = 20
) (
  input  logic [WIDTH-1:0] scr_i,
  input  logic             prev_i,
  output logic [WIDTH-1:0] nrzi_o,
  output logic             last_o
);
  always_comb begin
    logic acc;
    acc = prev_i;
    nrzi_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      acc = acc ^ scr_i[i];
      nrzi_o[i] = acc;
    end
  end

  assign last_o = nrzi_o[WIDTH-1];
endmodule

// File: rtl/sdi_chan_encoder.sv
module sdi_chan_encoder
  import sdi_coding_pkg::*;
#(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  generate
    if (WIDTH != WIDTH_SD && WIDTH != WIDTH_HD) begin : g_bad_width
      $error("sdi_chan_encoder: WIDTH must be 10 or 20");  // R7
    end
  endgenerate

  scr_hist_t        hist_q, hist_d;
  logic             last_q, last_d;
  logic [WIDTH-1:0] scr_word, nrzi_word;

  sdi_scrambler #(.WIDTH(WIDTH)) u_scr (
    .data_i (data_i),
    .hist_i (hist_q),
    .scr_o  (scr_word),
    .hist_o (hist_d)
  );

  sdi_nrzi #(.WIDTH(WIDTH)) u_nrzi (
    .scr_i  (scr_word),
    .prev_i (last_q),
    .nrzi_o (nrzi_word),
    .last_o (last_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      last_q <= 1'b0;
      data_o <= '0;
    end else if (ce_i) begin
      hist_q <= hist_d;
      last_q <= last_d;
      data_o <= nrzi_word;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(data_o) && $stable(hist_q) && $stable(last_q)); // R5

  AST_NRZI_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> (data_o ^ {data_o[WIDTH-2:0], $past(last_q)}) == $past(scr_word)); // R3

  AST_HIST_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> hist_q == $past(scr_word[WIDTH-1:WIDTH-SCR_LEN])); // R4

  AST_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> last_q == data_o[WIDTH-1]); // R4

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_ZERO: assert (data_o == '0 && hist_q == '0 && !last_q); // R1
    end
  end
endmodule

// File: tb/sdi_chan_encoder_bench.sv
module sdi_chan_encoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [19:0] d_hd = '0, q_hd;
  logic [9:0]  d_sd = '0, q_sd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdi_chan_encoder #(.WIDTH(20)) u_sdi_chan_encoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .data_i(d_hd), .data_o(q_hd));
  sdi_chan_encoder #(.WIDTH(10)) u_sdi_chan_encoder_sd (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .data_i(d_sd), .data_o(q_sd));

  // model state: h[0] is the most recent scrambled bit
  logic [8:0] mh_hd, mh_sd;
  logic       my_hd, my_sd;
  logic [19:0] exp_hd;
  logic [9:0]  exp_sd;
  // independent descrambler on the HD output
  logic [8:0] dq;
  logic       dpy;

  task automatic enc(input logic [19:0] d, input int n, inout logic [8:0] h,
                     inout logic y, output logic [19:0] o);
    o = '0;
    for (int i = 0; i < n; i++) begin
      logic s;
      s = d[i] ^ h[3] ^ h[8];
      h = {h[7:0], s};
      y = y ^ s;
      o[i] = y;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [19:0] act,
                     input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mh_hd = '0; mh_sd = '0; my_hd = 0; my_sd = 0;
    exp_hd = '0; exp_sd = '0; dq = '0; dpy = 0;
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic c, input logic [19:0] dh, input logic [9:0] ds);
    logic [19:0] t;
    logic [19:0] rec;
    ce = c; d_hd = dh; d_sd = ds;
    if (c) begin
      enc(dh, 20, mh_hd, my_hd, exp_hd);
      enc({10'h0, ds}, 10, mh_sd, my_sd, t);
      exp_sd = t[9:0];
    end
    @(negedge clk);
    if (c) begin
      chk(q_hd == exp_hd, "R4/R6 hd word", q_hd, exp_hd);
      chk(q_sd == exp_sd, "R4/R6 sd word", {10'h0, q_sd}, {10'h0, exp_sd});
      rec = '0;
      for (int i = 0; i < 20; i++) begin
        logic s;
        s = q_hd[i] ^ dpy;
        dpy = q_hd[i];
        rec[i] = s ^ dq[3] ^ dq[8];
        dq = {dq[7:0], s};
      end
      chk(rec == dh, "R8 descramble", rec, dh);
    end else begin
      chk(q_hd == exp_hd, "R5 hd hold", q_hd, exp_hd);
      chk(q_sd == exp_sd, "R5 sd hold", {10'h0, q_sd}, {10'h0, exp_sd});
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ce = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    chk(q_hd == '0, "R1 hd reset", q_hd, '0);
    chk(q_sd == '0, "R1 sd reset", {10'h0, q_sd}, '0);
    rst_n = 1;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5d1c0de);
    model_reset();
    @(negedge clk);
    do_reset();
    // R2/R3 impulse from zero state
    step(1, 20'h00001, 10'h001);
    chk(q_sd == 10'h10F, "R3 sd impulse", {10'h0, q_sd}, 20'h0010F);
    // tail of the impulse reaches into following words (R4)
    step(1, 20'h0, 10'h0);
    step(0, 20'hFFFFF, 10'h3FF);
    step(1, 20'h0, 10'h0);
    // all-ones words
    for (int k = 0; k < 6; k++) step(1, 20'hFFFFF, 10'h3FF);
    // random traffic with idle gaps (R5)
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, 20'($urandom), 10'($urandom));
    // mid-stream reset then restart (R1)
    do_reset();
    step(1, 20'h00001, 10'h001);
    chk(q_sd == 10'h10F, "R1 restart", {10'h0, q_sd}, 20'h0010F);
    for (int k = 0; k < 200; k++)
      step(($urandom % 3) != 0, 20'($urandom), 10'($urandom));
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule